// File: doc/BRIEF.md
# Accumulator Machine Sequencing Controller

This block sequences a small accumulator computer. It steps through four states: a reset state, an instruction fetch, and up to two execute steps. In each state it produces the strobes that drive the datapath: instruction register load, program counter increment and program counter load, memory address register load, accumulator load, memory output enable, the memory address source select, and the ALU function code.

Fetch is the same for every instruction. After fetch, the opcode in the instruction register decides what follows. A direct load takes two execute steps: the first captures the operand address, and the second reads memory through that address into the accumulator. An immediate load and an unconditional jump each take one execute step. Any other opcode does nothing and returns to fetch. The ALU carry flag is accepted as an input, but no sequence depends on it.

The strobes are decoded combinationally from the current state and the opcode. The six strobes are active low. The address select and the ALU function code are active high.

Top module: `accCtrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller enters the reset state. In that state all six strobes are high, `addrSel` is 0 and `aluFunc` is 3'b000 (hold).
- R2: The first clock edge with `rst` low, taken from the reset state, moves the controller to fetch.
- R3: In fetch, `irLoadN`, `pcIncN` and `memOeN` are low, the other strobes are high, `addrSel` is 0 (program counter) and `aluFunc` is 3'b000, whatever the opcode is.
- R4: Fetch is always followed by the first execute step.
- R5: For opcode 8'h01 (direct load), the first execute step drives `marLoadN`, `pcIncN` and `memOeN` low, with `addrSel` 0 and `aluFunc` 3'b000. A second execute step follows.
- R6: In the second execute step of a direct load, `accLoadN` and `memOeN` are low, `addrSel` is 1 (address register), `aluFunc` is 3'b001 (pass data), `pcIncN` is high, and fetch follows.
- R7: For opcode 8'h02 (immediate load), the single execute step drives `accLoadN`, `pcIncN` and `memOeN` low, with `addrSel` 0 and `aluFunc` 3'b001. Fetch follows.
- R8: For opcode 8'h12 (jump), the single execute step drives `pcLoadN` and `memOeN` low, with `pcIncN` high, `addrSel` 0 and `aluFunc` 3'b000. Fetch follows.
- R9: For any other opcode, the first execute step leaves every strobe high with `addrSel` 0 and `aluFunc` 3'b000, and fetch follows.
- R10: `pcIncN` and `pcLoadN` are never low together. `addrSel` is 1 only while `accLoadN` and `memOeN` are low.
- R11: `carryIn` has no effect on any output or on the state sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irOpcode | input | 8 | Opcode held in the instruction register |
| carryIn | input | 1 | ALU carry flag, accepted but unused |
| irLoadN | output | 1 | Instruction register load, active low |
| pcIncN | output | 1 | Program counter increment, active low |
| pcLoadN | output | 1 | Program counter load, active low |
| marLoadN | output | 1 | Address register load, active low |
| accLoadN | output | 1 | Accumulator load, active low |
| memOeN | output | 1 | Memory output enable, active low |
| addrSel | output | 1 | Memory address source: 0 program counter, 1 address register |
| aluFunc | output | 3 | ALU function: 3'b000 hold, 3'b001 pass data |

## Verification
The embedded assertions check these rules on every cycle: the state order (reset to fetch, fetch to first execute step, second execute step only after a direct load, then back to fetch), the quiet outputs in the reset state, and the exclusions between the program counter strobes and the address select. Only the bench scenarios can show that each opcode gives exactly the right strobe vector in each step. The bench sweeps all 256 opcodes with both carry values and shows that unknown opcodes and the carry flag leave everything untouched. It also shows that a reset raised in the middle of an instruction abandons it.

// File: rtl/accCtlPkg.sv
package accCtlPkg;
  localparam int OP_W  = 8;
  localparam int ALU_W = 3;

  typedef enum logic [1:0] {ST_RESET, ST_FETCH, ST_EX1, ST_EX2} ctlState_e;

  localparam logic [OP_W-1:0] OP_LD_DIR = 8'h01;
  localparam logic [OP_W-1:0] OP_LD_IMM = 8'h02;
  localparam logic [OP_W-1:0] OP_JUMP   = 8'h12;

  localparam logic [ALU_W-1:0] ALU_HOLD = 3'b000;
  localparam logic [ALU_W-1:0] ALU_PASS = 3'b001;

  // Strobes carried active high inside the block; the top inverts them.
  typedef struct packed {
    logic             irLoad;
    logic             pcInc;
    logic             pcLoad;
    logic             marLoad;
    logic             accLoad;
    logic             memOe;
    logic             addrMar;
    logic [ALU_W-1:0] aluFunc;
  } ctlStrobes_t;
endpackage

// File: rtl/seqState.sv
module seqState
  import accCtlPkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output ctlState_e       state
);
  ctlState_e nextState;

  always_comb begin
    unique case (state)
      ST_RESET: nextState = ST_FETCH;
      ST_FETCH: nextState = ST_EX1;
      ST_EX1:   nextState = (opcode == OP_LD_DIR) ? ST_EX2 : ST_FETCH;
      default:  nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= nextState;
  end

  p_reset_to_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_RESET |=> state == ST_FETCH);
  p_fetch_to_ex1_r4: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH |=> state == ST_EX1);
  p_ex2_after_direct_r5: assert property (@(posedge clk) disable iff (rst)
    state == ST_EX2 |-> ($past(state) == ST_EX1 && $past(opcode) == OP_LD_DIR));
  p_ex2_to_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    state == ST_EX2 |=> state == ST_FETCH);
endmodule

// File: rtl/strobeDecode.sv
module strobeDecode
  import accCtlPkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  ctlState_e       state,
  input  logic [OP_W-1:0] opcode,
  input  logic            carry,
  output ctlStrobes_t     strobes
);
  logic unusedCarry;
  assign unusedCarry = carry;  // R11: carry accepted, no path to outputs

  always_comb begin
    strobes = '0;
    strobes.aluFunc = ALU_HOLD;
    unique case (state)
      ST_FETCH: begin
        strobes.irLoad = 1'b1;
        strobes.pcInc  = 1'b1;
        strobes.memOe  = 1'b1;
      end
      ST_EX1: begin
        unique case (opcode)
          OP_LD_DIR: begin
            strobes.marLoad = 1'b1;
            strobes.pcInc   = 1'b1;
            strobes.memOe   = 1'b1;
          end
          OP_LD_IMM: begin
            strobes.accLoad = 1'b1;
            strobes.pcInc   = 1'b1;
            strobes.memOe   = 1'b1;
            strobes.aluFunc = ALU_PASS;
          end
          OP_JUMP: begin
            strobes.pcLoad = 1'b1;
            strobes.memOe  = 1'b1;
          end
          default: ;
        endcase
      end
      ST_EX2: begin
        if (opcode == OP_LD_DIR) begin
          strobes.accLoad = 1'b1;
          strobes.memOe   = 1'b1;
          strobes.addrMar = 1'b1;
          strobes.aluFunc = ALU_PASS;
        end
      end
      default: ;
    endcase
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    state == ST_RESET |-> (strobes == '0));
  p_pc_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(strobes.pcInc && strobes.pcLoad));
  p_mar_sel_r10: assert property (@(posedge clk) disable iff (rst)
    strobes.addrMar |-> (strobes.accLoad && strobes.memOe && state == ST_EX2));
endmodule

// File: rtl/accCtrl.sv
module accCtrl
  import accCtlPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  irOpcode,
  input  logic             carryIn,
  output logic             irLoadN,
  output logic             pcIncN,
  output logic             pcLoadN,
  output logic             marLoadN,
  output logic             accLoadN,
  output logic             memOeN,
  output logic             addrSel,
  output logic [ALU_W-1:0] aluFunc
);
  ctlState_e   state;
  ctlStrobes_t strobes;

  seqState u_seq (
    .clk    (clk),
    .rst    (rst),
    .opcode (irOpcode),
    .state  (state)
  );

  strobeDecode u_dec (
    .clk     (clk),
    .rst     (rst),
    .state   (state),
    .opcode  (irOpcode),
    .carry   (carryIn),
    .strobes (strobes)
  );

  assign irLoadN  = ~strobes.irLoad;
  assign pcIncN   = ~strobes.pcInc;
  assign pcLoadN  = ~strobes.pcLoad;
  assign marLoadN = ~strobes.marLoad;
  assign accLoadN = ~strobes.accLoad;
  assign memOeN   = ~strobes.memOe;
  assign addrSel  = strobes.addrMar;
  assign aluFunc  = strobes.aluFunc;
endmodule

// File: tb/test_accCtrl.sv
module test_accCtrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] irOpcode;
  logic       carryIn;
  logic       irLoadN, pcIncN, pcLoadN, marLoadN, accLoadN, memOeN, addrSel;
  logic [2:0] aluFunc;

  int checks = 0;
  int fails  = 0;
  int mState = 0;  // model: 0 reset, 1 fetch, 2 ex1, 3 ex2

  always #(CLK_PERIOD/2) clk = ~clk;

  accCtrl i_accCtrl (
    .clk(clk), .rst(rst), .irOpcode(irOpcode), .carryIn(carryIn),
    .irLoadN(irLoadN), .pcIncN(pcIncN), .pcLoadN(pcLoadN),
    .marLoadN(marLoadN), .accLoadN(accLoadN), .memOeN(memOeN),
    .addrSel(addrSel), .aluFunc(aluFunc)
  );

  // {irLoadN,pcIncN,pcLoadN,marLoadN,accLoadN,memOeN,addrSel,aluFunc}
  function automatic logic [9:0] expVec(int st, logic [7:0] op);
    case (st)
      1: return 10'b001110_0_000;                     // R3
      2: case (op)
           8'h01:   return 10'b101010_0_000;          // R5
           8'h02:   return 10'b101100_0_001;          // R7
           8'h12:   return 10'b110110_0_000;          // R8
           default: return 10'b111111_0_000;          // R9
         endcase
      3: return (op == 8'h01) ? 10'b111100_1_001 : 10'b111111_0_000; // R6
      default: return 10'b111111_0_000;               // R1
    endcase
  endfunction

  function automatic string tagOf(int st, logic [7:0] op);
    case (st)
      0: return "R1/R2";
      1: return "R3/R4";
      2: case (op)
           8'h01: return "R5/R11";
           8'h02: return "R7/R11";
           8'h12: return "R8/R11";
           default: return "R9/R11";
         endcase
      default: return "R6";
    endcase
  endfunction

  task automatic checkNow();
    logic [9:0] got, exp;
    got = {irLoadN, pcIncN, pcLoadN, marLoadN, accLoadN, memOeN, addrSel, aluFunc};
    exp = expVec(mState, irOpcode);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s state=%0d op=%h carry=%b got=%b exp=%b",
               tagOf(mState, irOpcode), mState, irOpcode, carryIn, got, exp);
    end
    // R10: program counter strobes exclusive
    checks++;
    if (pcIncN === 1'b0 && pcLoadN === 1'b0) begin
      fails++;
      $display("FAIL R10 pcIncN=%b pcLoadN=%b exp not both 0", pcIncN, pcLoadN);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst)              mState = 0;
    else case (mState)
      0: mState = 1;
      1: mState = 2;
      2: mState = (irOpcode == 8'h01) ? 3 : 1;
      default: mState = 1;
    endcase
    @(negedge clk);
    checkNow();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; irOpcode = 8'h00; carryIn = 1'b0;
    tick(); tick();                    // R1: reset state quiet
    rst = 1'b0;
    tick();                            // R2: to fetch
    for (int op = 0; op < 256; op++) begin
      for (int c = 0; c < 2; c++) begin
        irOpcode = op[7:0];
        carryIn  = c[0];               // R11: carry must not matter
        #1 checkNow();                 // R3: fetch ignores opcode
        tick();                        // R4: first execute step
        while (mState != 1) tick();
      end
    end
    // R1: reset in the middle of a direct load abandons it
    irOpcode = 8'h01;
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();                            // R2
    tick();
    tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule